// File: doc/BRIEF.md
# Fan PWM and Tachometer Supervisor

This block drives a cooling fan through a pulse-width-modulated output and watches the fan's tachometer line. Software sets a pulse width against a fixed PWM period that is built into the block. The block measures the time between rising tach edges in system clock cycles. It checks each result against an expected period and tolerance that software programs. A missing tach signal is reported as a fault once a timeout expires.

The block can also raise the duty cycle on its own. When the raw temperature input crosses a hot threshold, it forces full duty and reports a hardware duty request. Any duty change, whether from hardware or from software, opens a settle window. Tach faults are not reported while the window is open. When the window closes, a duty-change event marks that the fan should have reached its new speed.

Four events feed a sticky pending register with write-one-to-clear, a mask register and an active-high level interrupt. Register access is a single-cycle write strobe with a combinational read.

Top module: `fan_supervisor`

## Requirements
- R1: After `rst_n` the mask register (0x40) reads 0xF and the following all read 0: `pwm_out`, `irq`, the measured period (0xC4), pending (0x44) and the run bit (0x80 bit 0). While the run bit is 0, `pwm_out` stays low and no pending bit is set, even if the width is written or the tach line is idle.
- R2: With the run bit set, in every window of PWM_PERIOD consecutive cycles `pwm_out` is high for min(width, PWM_PERIOD) cycles. Width 0 keeps it low. A width at or above the period keeps it high. Register 0xC0 reads PWM_PERIOD.
- R3: Register 0xC4 holds the number of clock cycles between the last two rising tach edges. Each new value sets pending bit 3. After reset or a timeout, the first edge only arms the measurement.
- R4: A measurement m sets pending bit 1 when m > E+T or m < E-T. E is the expected period (0x88) and T is the tolerance (0x8C). Both bounds are inclusive and pass. If E is 0, no check is made.
- R5: If no rising tach edge arrives within TACH_TIMEOUT cycles, pending bit 1 is set, 0xC4 is cleared to 0, and the next edge only re-arms the measurement.
- R6: A write to the width register (0x84) while running takes effect on the PWM at once. It also opens a settle window of SETTLE_CYCLES cycles. Pending bit 0 is set when the window closes, not before.
- R7: Register 0xC8 reads the raw temperature. When it moves from below TEMP_HOT to TEMP_HOT or above, the following happen: pending bit 2 is set, the width is forced to PWM_PERIOD, a settle window opens, and pending bit 0 is set when that window closes.
- R8: While a settle window is open, neither out-of-window measurements nor timeouts set pending bit 1. Measurements still update 0xC4 and set bit 3.
- R9: Pending bits stay set until a 1 is written to the same bit of 0x44. An event in the same cycle as its clear wins. A 1 in a mask bit (0x40) blocks that source from the interrupt but leaves pending unchanged. Register 0x48 reads pending AND NOT mask.
- R10: `irq` is high exactly while at least one pending bit is set whose mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| temp_raw | input | TEMP_W | Raw temperature code |
| tach_in | input | 1 | Asynchronous fan tachometer line |
| pwm_out | output | 1 | Fan PWM drive |
| irq | output | 1 | Active-high level interrupt |

## Verification
Some properties are checked on every cycle. The pending register holds its value unless it is written or an event fires, and a written clear or a new event lands on the right bits. An idle or zero-width PWM stays low, and a full-width PWM stays high. No tach fault appears during a settle window. The idle-gap counter never passes the timeout, and every measurement event carries a nonzero period. A hot crossing always leaves the width at full period. Other behaviour is shown only by the bench scenarios: the exact window boundaries, timeout recovery, the length of the settle delay before the duty-change event, the PWM high-cycle counts, and the interrupt under different mask settings.

// File: rtl/fan_pkg.sv
package fan_pkg;
   localparam int unsigned REG_DW  = 32;
   localparam int unsigned ADDR_W  = 8;
   localparam int unsigned NUM_EVT = 4;

   // event bit positions inside the pending, mask and source registers
   localparam int unsigned EV_DUTY_DONE = 0;
   localparam int unsigned EV_TACH_BAD  = 1;
   localparam int unsigned EV_HOT_REQ   = 2;
   localparam int unsigned EV_MEAS      = 3;

   localparam logic [ADDR_W-1:0] A_IRQ_MASK  = 8'h40;
   localparam logic [ADDR_W-1:0] A_IRQ_PEND  = 8'h44;
   localparam logic [ADDR_W-1:0] A_IRQ_SRC   = 8'h48;
   localparam logic [ADDR_W-1:0] A_CORE_RUN  = 8'h80;
   localparam logic [ADDR_W-1:0] A_WIDTH     = 8'h84;
   localparam logic [ADDR_W-1:0] A_TACH_EXP  = 8'h88;
   localparam logic [ADDR_W-1:0] A_TACH_TOL  = 8'h8C;
   localparam logic [ADDR_W-1:0] A_PERIOD    = 8'hC0;
   localparam logic [ADDR_W-1:0] A_TACH_MEAS = 8'hC4;
   localparam logic [ADDR_W-1:0] A_TEMP      = 8'hC8;

   typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
   parameter int unsigned PERIOD  = 1000,
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned WIDTH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [WIDTH_W-1:0] width,
   output logic               pwm_out
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] phase_q;
   logic             pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         pwm_q   <= 1'b0;
      end else if (!run) begin
         phase_q <= '0;
         pwm_q   <= 1'b0;
      end else begin
         phase_q <= (phase_q == CNT_LAST) ? '0 : phase_q + 1'b1;
         pwm_q   <= WIDTH_W'(phase_q) < width;
      end
   end

   assign pwm_out = pwm_q;

   // R1
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !pwm_out);
   // R2
   full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) && ($past(width) >= WIDTH_W'(PERIOD)) |-> pwm_out);
   // R2
   zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(width) == '0 |-> !pwm_out);
endmodule

// File: rtl/fan_tach_mon.sv
module fan_tach_mon #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TIMEOUT     = 1000,
   parameter int unsigned CNT_W       = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tach_in,
   input  logic             quiet,
   input  logic [CNT_W-1:0] exp_period,
   input  logic [CNT_W-1:0] tolerance,
   output logic [CNT_W-1:0] meas,
   output logic             meas_evt,
   output logic             err_evt
);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(TIMEOUT - 1);

   logic tach_s;

   if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], tach_in};
      end
      assign tach_s = chain_q[SYNC_STAGES-1];
   end else begin : g_single
      logic one_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) one_q <= 1'b0;
         else        one_q <= tach_in;
      end
      assign tach_s = one_q;
   end

   logic             prev_q;
   logic             rise;
   logic [CNT_W-1:0] gap_q;
   logic [CNT_W-1:0] meas_q;
   logic             armed_q;
   logic             meas_evt_q;
   logic             err_evt_q;
   logic [CNT_W:0]   span;
   logic [CNT_W:0]   upper;
   logic             outside;

   always_comb begin
      rise    = tach_s & ~prev_q;
      span    = {1'b0, gap_q} + 1'b1;
      upper   = {1'b0, exp_period} + {1'b0, tolerance};
      outside = (span > upper) || ((span + {1'b0, tolerance}) < {1'b0, exp_period});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= 1'b0;
         gap_q      <= '0;
         meas_q     <= '0;
         armed_q    <= 1'b0;
         meas_evt_q <= 1'b0;
         err_evt_q  <= 1'b0;
      end else if (!run) begin
         prev_q     <= tach_s;
         gap_q      <= '0;
         meas_q     <= '0;
         armed_q    <= 1'b0;
         meas_evt_q <= 1'b0;
         err_evt_q  <= 1'b0;
      end else begin
         prev_q     <= tach_s;
         meas_evt_q <= 1'b0;
         err_evt_q  <= 1'b0;
         if (rise) begin
            gap_q   <= '0;
            armed_q <= 1'b1;
            if (armed_q) begin
               meas_q     <= span[CNT_W-1:0];
               meas_evt_q <= 1'b1;
               err_evt_q  <= !quiet && (exp_period != '0) && outside;
            end
         end else if (gap_q == GAP_LAST) begin
            gap_q     <= '0;
            armed_q   <= 1'b0;
            meas_q    <= '0;
            err_evt_q <= !quiet;
         end else begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   assign meas     = meas_q;
   assign meas_evt = meas_evt_q;
   assign err_evt  = err_evt_q;

   // R8
   quiet_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |=> !err_evt);
   // R3
   meas_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meas_evt |-> meas != '0);
   // R5
   gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q < CNT_W'(TIMEOUT));
endmodule

// File: rtl/fan_duty_ctrl.sv
module fan_duty_ctrl #(
   parameter int unsigned PERIOD   = 1000,
   parameter int unsigned WIDTH_W  = 16,
   parameter int unsigned TEMP_W   = 12,
   parameter int unsigned TEMP_HOT = 2600,
   parameter int unsigned SETTLE   = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               sw_we,
   input  logic [WIDTH_W-1:0] sw_width,
   input  logic [TEMP_W-1:0]  temp_raw,
   output logic [WIDTH_W-1:0] width,
   output logic               settling,
   output logic               done_evt,
   output logic               hot_evt
);
   localparam int unsigned SET_W = $clog2(SETTLE + 1);

   logic [WIDTH_W-1:0] width_q;
   logic [SET_W-1:0]   settle_q;
   logic               hot_q;
   logic               done_q;
   logic               hot_evt_q;
   logic               hot_now;
   logic               hot_rise;
   logic               trig;

   always_comb begin
      hot_now  = temp_raw >= TEMP_W'(TEMP_HOT);
      hot_rise = run && hot_now && !hot_q;
      trig     = hot_rise || (run && sw_we);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q <= '0;
      end else if (hot_rise) begin
         width_q <= WIDTH_W'(PERIOD);
      end else if (sw_we) begin
         width_q <= sw_width;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_q  <= '0;
         hot_q     <= 1'b0;
         done_q    <= 1'b0;
         hot_evt_q <= 1'b0;
      end else if (!run) begin
         settle_q  <= '0;
         hot_q     <= 1'b0;
         done_q    <= 1'b0;
         hot_evt_q <= 1'b0;
      end else begin
         hot_q     <= hot_now;
         hot_evt_q <= hot_rise;
         done_q    <= (settle_q == SET_W'(1)) && !trig;
         if (trig)                settle_q <= SET_W'(SETTLE);
         else if (settle_q != '0) settle_q <= settle_q - 1'b1;
      end
   end

   assign width    = width_q;
   assign settling = settle_q != '0;
   assign done_evt = done_q;
   assign hot_evt  = hot_evt_q;

   // R7
   hot_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hot_evt |-> width == WIDTH_W'(PERIOD));
   // R6
   done_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |-> !settling);
   // R6
   settle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && sw_we |=> settling);
endmodule

// File: rtl/fan_irq_ctrl.sv
module fan_irq_ctrl
   import fan_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  evt_vec_t evt,
   input  logic     mask_we,
   input  evt_vec_t mask_wdata,
   input  logic     clr_we,
   input  evt_vec_t clr_bits,
   output evt_vec_t mask,
   output evt_vec_t pend,
   output logic     irq
);
   evt_vec_t mask_q;
   evt_vec_t pend_q;
   evt_vec_t clr_eff;

   assign clr_eff = clr_we ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         pend_q <= '0;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         pend_q <= (pend_q & ~clr_eff) | evt;
      end
   end

   assign mask = mask_q;
   assign pend = pend_q;
   assign irq  = |(pend_q & ~mask_q);

   // R9
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we && (evt == '0) |=> $stable(pend));
   // R9
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && (evt == '0) |=> (pend & $past(clr_bits)) == '0);
   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt != '0 |=> (pend & $past(evt)) == $past(evt));
endmodule

// File: rtl/fan_supervisor.sv
module fan_supervisor
   import fan_pkg::*;
#(
   parameter int unsigned PWM_PERIOD    = 1000,
   parameter int unsigned WIDTH_W       = 16,
   parameter int unsigned TACH_TIMEOUT  = 1000000,
   parameter int unsigned SETTLE_CYCLES = 500000000,
   parameter int unsigned TEMP_W        = 12,
   parameter int unsigned TEMP_HOT      = 2600,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [TEMP_W-1:0] temp_raw,
   input  logic              tach_in,
   output logic              pwm_out,
   output logic              irq
);
   localparam int unsigned PCNT_W = (PWM_PERIOD > 2) ? $clog2(PWM_PERIOD) : 1;
   localparam int unsigned TCNT_W = $clog2(TACH_TIMEOUT + 1);

   initial begin : param_chk
      assert (PWM_PERIOD >= 2) else $error("PWM_PERIOD too small");
      assert (WIDTH_W > PCNT_W && WIDTH_W <= REG_DW) else $error("WIDTH_W out of range");
      assert (TACH_TIMEOUT >= 4 && TCNT_W <= REG_DW) else $error("TACH_TIMEOUT out of range");
      assert (SETTLE_CYCLES >= 2) else $error("SETTLE_CYCLES too small");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES too small");
      assert (TEMP_W <= REG_DW && TEMP_HOT < (64'd1 << TEMP_W)) else $error("TEMP range");
   end

   logic              run_q;
   logic [TCNT_W-1:0] exp_q;
   logic [TCNT_W-1:0] tol_q;
   logic              unused_wdata;

   logic               sw_we;
   logic [WIDTH_W-1:0] width;
   logic               settling;
   logic               done_evt;
   logic               hot_evt;
   logic [TCNT_W-1:0]  meas;
   logic               meas_evt;
   logic               err_evt;
   evt_vec_t           evt;
   evt_vec_t           mask;
   evt_vec_t           pend;
   logic               mask_we;
   logic               clr_we;

   assign unused_wdata = ^reg_wdata;
   assign sw_we   = reg_we && (reg_addr == A_WIDTH);
   assign mask_we = reg_we && (reg_addr == A_IRQ_MASK);
   assign clr_we  = reg_we && (reg_addr == A_IRQ_PEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         exp_q <= '0;
         tol_q <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            A_CORE_RUN: run_q <= reg_wdata[0];
            A_TACH_EXP: exp_q <= reg_wdata[TCNT_W-1:0];
            A_TACH_TOL: tol_q <= reg_wdata[TCNT_W-1:0];
            default: ;
         endcase
      end
   end

   fan_duty_ctrl #(
      .PERIOD  (PWM_PERIOD),
      .WIDTH_W (WIDTH_W),
      .TEMP_W  (TEMP_W),
      .TEMP_HOT(TEMP_HOT),
      .SETTLE  (SETTLE_CYCLES)
   ) i_duty (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .sw_we   (sw_we),
      .sw_width(reg_wdata[WIDTH_W-1:0]),
      .temp_raw(temp_raw),
      .width   (width),
      .settling(settling),
      .done_evt(done_evt),
      .hot_evt (hot_evt)
   );

   fan_pwm_gen #(
      .PERIOD (PWM_PERIOD),
      .CNT_W  (PCNT_W),
      .WIDTH_W(WIDTH_W)
   ) i_pwm (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q),
      .width  (width),
      .pwm_out(pwm_out)
   );

   fan_tach_mon #(
      .SYNC_STAGES(SYNC_STAGES),
      .TIMEOUT    (TACH_TIMEOUT),
      .CNT_W      (TCNT_W)
   ) i_tach (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .tach_in   (tach_in),
      .quiet     (settling),
      .exp_period(exp_q),
      .tolerance (tol_q),
      .meas      (meas),
      .meas_evt  (meas_evt),
      .err_evt   (err_evt)
   );

   always_comb begin
      evt               = '0;
      evt[EV_DUTY_DONE] = done_evt;
      evt[EV_TACH_BAD]  = err_evt;
      evt[EV_HOT_REQ]   = hot_evt;
      evt[EV_MEAS]      = meas_evt;
   end

   fan_irq_ctrl i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .mask_we   (mask_we),
      .mask_wdata(reg_wdata[NUM_EVT-1:0]),
      .clr_we    (clr_we),
      .clr_bits  (reg_wdata[NUM_EVT-1:0]),
      .mask      (mask),
      .pend      (pend),
      .irq       (irq)
   );

   always_comb begin
      case (reg_addr)
         A_IRQ_MASK:  reg_rdata = REG_DW'(mask);
         A_IRQ_PEND:  reg_rdata = REG_DW'(pend);
         A_IRQ_SRC:   reg_rdata = REG_DW'(pend & ~mask);
         A_CORE_RUN:  reg_rdata = REG_DW'(run_q);
         A_WIDTH:     reg_rdata = REG_DW'(width);
         A_TACH_EXP:  reg_rdata = REG_DW'(exp_q);
         A_TACH_TOL:  reg_rdata = REG_DW'(tol_q);
         A_PERIOD:    reg_rdata = REG_DW'(PWM_PERIOD);
         A_TACH_MEAS: reg_rdata = REG_DW'(meas);
         A_TEMP:      reg_rdata = REG_DW'(temp_raw);
         default:     reg_rdata = '0;
      endcase
   end
endmodule

// File: tb/test_fan_supervisor.sv
module test_fan_supervisor;
   localparam int PER    = 10;
   localparam int SETTLE = 300;
   localparam int TMO    = 500;
   localparam int HOT    = 100;
   localparam int NVEC   = 7;
   // tach period, expected period, tolerance, expect error bit
   localparam int VEC [0:NVEC-1][0:3] = '{
      '{50, 50, 0, 0}, '{45, 50, 5, 0}, '{44, 50, 5, 1}, '{55, 50, 5, 0},
      '{56, 50, 5, 1}, '{64, 60, 2, 1}, '{80,  0, 0, 0}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = 8'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic [11:0] temp_raw = 12'd20;
   logic        tach_in = 1'b0;
   logic        pwm_out;
   logic        irq;
   int          tach_per = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   fan_supervisor #(
      .PWM_PERIOD(PER), .WIDTH_W(16), .TACH_TIMEOUT(TMO), .SETTLE_CYCLES(SETTLE),
      .TEMP_W(12), .TEMP_HOT(HOT), .SYNC_STAGES(2)
   ) i_fan_supervisor (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .temp_raw(temp_raw),
      .tach_in(tach_in), .pwm_out(pwm_out), .irq(irq)
   );

   // background tach source, one pulse of tach_per cycles at a time
   initial begin
      forever begin
         if (tach_per == 0) begin
            tach_in = 1'b0;
            @(negedge clk);
         end else begin
            automatic int p = tach_per;
            tach_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            tach_in = 1'b0;
            repeat (p - p / 2) @(negedge clk);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic count_high(output int n);
      n = 0;
      for (int i = 0; i < PER; i++) begin
         @(negedge clk);
         if (pwm_out) n++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pwm_out", int'(pwm_out), 0);
      check("R1 irq", int'(irq), 0);
      rd(8'h40, d); check("R1 mask", int'(d), 15);
      rd(8'hC4, d); check("R1 meas", int'(d), 0);
      rd(8'h80, d); check("R1 run", int'(d), 0);
      rd(8'hC0, d); check("R2 period reg", int'(d), PER);
      // R1 held in soft reset: width write and idle tach do nothing
      wr(8'h84, 32'd5);
      repeat (TMO + 100) @(negedge clk);
      rd(8'h44, d); check("R1 pending idle", int'(d), 0);
      count_high(n); check("R1 pwm idle", n, 0);

      wr(8'h80, 32'd1);
      wr(8'h40, 32'd0);

      // R3 R4 vector table
      for (int v = 0; v < NVEC; v++) begin
         tach_per = VEC[v][0];
         wr(8'h88, VEC[v][1]);
         wr(8'h8C, VEC[v][2]);
         repeat (4 * VEC[v][0]) @(negedge clk);
         wr(8'h44, 32'hF);
         repeat (2 * VEC[v][0] + 8) @(negedge clk);
         rd(8'hC4, d); check("R3 measured period", int'(d), VEC[v][0]);
         rd(8'h44, d);
         check("R3 new measurement bit", int'(d[3]), 1);
         check("R4 window error bit", int'(d[1]), VEC[v][3]);
      end

      // R5 timeout
      tach_per = 0;
      repeat (100) @(negedge clk);
      wr(8'h44, 32'hF);
      repeat (TMO + 20) @(negedge clk);
      rd(8'h44, d); check("R5 timeout error bit", int'(d[1]), 1);
      rd(8'hC4, d); check("R5 measurement cleared", int'(d), 0);

      // R2 R6 software width
      wr(8'h44, 32'hF);
      wr(8'h84, 32'd3);
      repeat (5) @(negedge clk);
      count_high(n); check("R2 duty 3 of 10", n, 3);
      repeat (130) @(negedge clk);
      rd(8'h44, d); check("R6 no change event during settle", int'(d[0]), 0);
      repeat (200) @(negedge clk);
      rd(8'h44, d); check("R6 change event after settle", int'(d[0]), 1);
      wr(8'h84, 32'd0);
      repeat (5) @(negedge clk);
      count_high(n); check("R2 duty zero", n, 0);
      wr(8'h84, 32'd15);
      repeat (5) @(negedge clk);
      count_high(n); check("R2 duty above period", n, PER);
      rd(8'h84, d); check("R6 width readback", int'(d), 15);

      // R9 R10 mask, source, clear
      repeat (SETTLE + 20) @(negedge clk);
      wr(8'h40, 32'hE);
      #1 check("R10 irq with bit0 enabled", int'(irq), 1);
      rd(8'h48, d); check("R9 source bit0 only", int'(d), 1);
      wr(8'h40, 32'hF);
      #1 check("R10 irq all masked", int'(irq), 0);
      rd(8'h48, d); check("R9 source all masked", int'(d), 0);
      rd(8'h44, d); check("R9 mask leaves pending", int'(d[0]), 1);
      wr(8'h40, 32'hE);
      wr(8'h44, 32'h1);
      rd(8'h44, d); check("R9 write one clears", int'(d[0]), 0);
      #1 check("R10 irq after clear", int'(irq), 0);

      // R7 R8 temperature request with settle suppression
      wr(8'h40, 32'h0);
      tach_per = 60;
      wr(8'h88, 32'd40);
      wr(8'h8C, 32'd4);
      repeat (200) @(negedge clk);
      temp_raw = 12'd150;
      repeat (3) @(negedge clk);
      rd(8'h44, d); check("R7 hot request bit", int'(d[2]), 1);
      rd(8'h84, d); check("R7 width forced full", int'(d), PER);
      rd(8'hC8, d); check("R7 temperature reg", int'(d), 150);
      wr(8'h44, 32'hF);
      repeat (200) @(negedge clk);
      rd(8'h44, d);
      check("R8 no error while settling", int'(d[1]), 0);
      check("R8 measurements continue", int'(d[3]), 1);
      check("R7 no change event yet", int'(d[0]), 0);
      repeat (120) @(negedge clk);
      rd(8'h44, d); check("R7 change event after settle", int'(d[0]), 1);
      #1 check("R10 irq pending", int'(irq), 1);
      repeat (130) @(negedge clk);
      rd(8'h44, d); check("R8 error resumes after settle", int'(d[1]), 1);

      finish_run();
   end
endmodule